// File: doc/BRIEF.md
# CPU Clock Source and Ratio Control Register Model

This block models the control registers of a processor clock domain. It holds a source-select bit that picks the main PLL or an alternate source, plus four 3-bit ratio fields. The fields are the core ratio and the trace-bus ratio in a first ratio register, and the performance-monitor ratio and the copy ratio in a second ratio register. Status registers report the source position and the settling state of each ratio field.

The block does not acknowledge a change at once. A source change shows a "moving" code for a set number of cycles before it reports the new position. A ratio field that receives a new value reports busy for a set number of cycles. This lets a frequency-change sequencer be exercised against realistic wait behaviour. The sequencer writes through a one-cycle write strobe, reads through a combinational read port, and polls the status registers until they show the settled state.

Top module: `cpuclk_ctrl_regs`

## Requirements
- R1: After reset, the source-select register reads 0 and the source-status register reads 0x0001_0000 (code 1 in bits 18:16). Both ratio registers and both busy registers read 0.
- R2: Offset 0x200 holds the source bit at bit 16: 0 selects the main PLL and 1 selects the alternate source. All other bits of 0x200 read 0. When settled, bits 18:16 of offset 0x400 read 1 for the main source and 2 for the alternate source; all other bits of 0x400 read 0.
- R3: A write that flips the source bit makes bits 18:16 of 0x400 read 4 for exactly MUX_SETTLE cycles after the write edge, and then read the new position. A write that leaves the source bit unchanged starts no transition.
- R4: Offset 0x500 holds the core ratio at bits 2:0 and the trace-bus ratio at bits 18:16. Offset 0x504 holds the copy ratio at bits 2:0 and the performance-monitor ratio at bits 6:4. Written values read back from the next cycle, and every other bit reads 0.
- R5: A write that changes a ratio field sets that field's busy bit for exactly DIV_SETTLE cycles. The busy bit sits at the field's lowest bit position in 0x600 (for 0x500) or 0x604 (for 0x504). A field written with its current value while idle stays idle.
- R6: A write to a field that is still busy, with any value, restarts its busy time at the full DIV_SETTLE cycles.
- R7: Reads of any offset other than the six listed return 0. Writes to such offsets, and writes to the status offsets 0x400, 0x600 and 0x604, change no register and start no transition.
- R8: A second flip of the source bit while a transition is in progress restarts the moving time at the full MUX_SETTLE cycles, and the final position is that of the last write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W | Byte offset for both read and write |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for `addr` |

## Verification
A wrong settle counter shows at the status offsets as a busy or moving window one or more cycles too long or too short. The window is measured cycle by cycle from the first sample after the write edge. A wrong ratio or source storage, or a write leaking into another field, shows on the next read of the ratio registers or as a stray busy bit in the same window. The bench measures each window as a count and compares it with the parameter, so an off-by-one fault is seen at the first write that should start a window.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

  localparam int RATIO_W    = 3;
  localparam int NUM_FIELDS = 4;

  // Offsets that a sequencer decodes
  localparam logic [11:0] OFS_SRC_SEL  = 12'h200;
  localparam logic [11:0] OFS_SRC_STAT = 12'h400;
  localparam logic [11:0] OFS_RATIO_A  = 12'h500;
  localparam logic [11:0] OFS_RATIO_B  = 12'h504;
  localparam logic [11:0] OFS_BUSY_A   = 12'h600;
  localparam logic [11:0] OFS_BUSY_B   = 12'h604;

  localparam int SRC_BIT      = 16;
  localparam int SRC_CODE_LSB = 16;

  typedef enum logic [2:0] {
    SRC_CODE_MAIN   = 3'd1,
    SRC_CODE_ALT    = 3'd2,
    SRC_CODE_MOVING = 3'd4
  } src_code_e;

  // Status code for the source mux
  function automatic src_code_e src_code(input logic moving, input logic alt);
    if (moving)   return SRC_CODE_MOVING;
    else if (alt) return SRC_CODE_ALT;
    else          return SRC_CODE_MAIN;
  endfunction

  // Field 0 core, 1 trace bus (register A); 2 copy, 3 perf monitor (register B)
  function automatic logic field_in_a(input int idx);
    return idx < 2;
  endfunction

  function automatic int field_lsb(input int idx);
    case (idx)
      0:       return 0;
      1:       return 16;
      2:       return 0;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/cpuclk_settle_timer.sv
module cpuclk_settle_timer #(
  parameter int SETTLE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(SETTLE);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_LOAD_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);  // R5
  AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> !busy);  // R3

endmodule

// File: rtl/cpuclk_div_field.sv
module cpuclk_div_field #(
  parameter int SETTLE = 6,
  parameter int W      = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] ratio,
  output logic         busy
);
  logic field_changed;
  logic restart;

  assign field_changed = wr_hit && (wr_val != ratio);
  assign restart       = field_changed || (wr_hit && busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ratio <= '0;
    else if (wr_hit) ratio <= wr_val;
  end

  cpuclk_settle_timer #(.SETTLE(SETTLE)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (restart),
    .busy (busy)
  );

  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ratio));  // R4
  AST_SAME_VALUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !busy && (wr_val == ratio)) |=> !busy);  // R5

endmodule

// File: rtl/cpuclk_ctrl_regs.sv
module cpuclk_ctrl_regs
  import cpuclk_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int MUX_SETTLE = 4,
  parameter int DIV_SETTLE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  // Decoded events, named for the assertions
  logic sel_wr, ratio_a_wr, ratio_b_wr, src_flip;
  logic addr_mapped;
  logic src_alt, mux_moving;
  logic [2:0] src_stat_code;

  assign sel_wr     = wr_en && (addr == ADDR_W'(OFS_SRC_SEL));
  assign ratio_a_wr = wr_en && (addr == ADDR_W'(OFS_RATIO_A));
  assign ratio_b_wr = wr_en && (addr == ADDR_W'(OFS_RATIO_B));
  assign src_flip   = sel_wr && (wr_data[SRC_BIT] != src_alt);

  assign addr_mapped = (addr == ADDR_W'(OFS_SRC_SEL))  || (addr == ADDR_W'(OFS_SRC_STAT)) ||
                       (addr == ADDR_W'(OFS_RATIO_A))  || (addr == ADDR_W'(OFS_RATIO_B))  ||
                       (addr == ADDR_W'(OFS_BUSY_A))   || (addr == ADDR_W'(OFS_BUSY_B));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_alt <= 1'b0;
    else if (sel_wr) src_alt <= wr_data[SRC_BIT];
  end

  cpuclk_settle_timer #(.SETTLE(MUX_SETTLE)) u_mux_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (src_flip),
    .busy (mux_moving)
  );

  assign src_stat_code = src_code(mux_moving, src_alt);

  // Ratio fields
  logic [RATIO_W-1:0]    f_ratio [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] f_busy;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam int LSB = field_lsb(g);
    logic hit;
    assign hit = field_in_a(g) ? ratio_a_wr : ratio_b_wr;

    cpuclk_div_field #(.SETTLE(DIV_SETTLE), .W(RATIO_W)) u_field (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_hit(hit),
      .wr_val(wr_data[LSB +: RATIO_W]),
      .ratio (f_ratio[g]),
      .busy  (f_busy[g])
    );
  end

  // Read words
  logic [DATA_W-1:0] ratio_word_a, ratio_word_b, busy_word_a, busy_word_b;
  logic [DATA_W-1:0] sel_word, stat_word;

  always_comb begin
    ratio_word_a = '0;
    ratio_word_b = '0;
    busy_word_a  = '0;
    busy_word_b  = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (field_in_a(i)) begin
        ratio_word_a[field_lsb(i) +: RATIO_W] = f_ratio[i];
        busy_word_a[field_lsb(i)]             = f_busy[i];
      end else begin
        ratio_word_b[field_lsb(i) +: RATIO_W] = f_ratio[i];
        busy_word_b[field_lsb(i)]             = f_busy[i];
      end
    end
    sel_word                           = '0;
    sel_word[SRC_BIT]                  = src_alt;
    stat_word                          = '0;
    stat_word[SRC_CODE_LSB +: 3]       = src_stat_code;
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(OFS_SRC_SEL))       rd_data = sel_word;
    else if (addr == ADDR_W'(OFS_SRC_STAT)) rd_data = stat_word;
    else if (addr == ADDR_W'(OFS_RATIO_A))  rd_data = ratio_word_a;
    else if (addr == ADDR_W'(OFS_RATIO_B))  rd_data = ratio_word_b;
    else if (addr == ADDR_W'(OFS_BUSY_A))   rd_data = busy_word_a;
    else if (addr == ADDR_W'(OFS_BUSY_B))   rd_data = busy_word_b;
  end

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  AST_SRC_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(src_stat_code));  // R2
  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(src_alt));  // R2
  AST_MOVE_NEEDS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mux_moving) |-> $past(src_flip));  // R3
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_mapped |-> (rd_data == '0));  // R7

endmodule

// File: tb/cpuclk_ctrl_regs_tb.sv
`timescale 1ns/1ps
module cpuclk_ctrl_regs_tb;
  localparam int MS = 4;
  localparam int DS = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  logic [2:0] rat [4];
  logic       alt;

  always #10 clk = ~clk;

  cpuclk_ctrl_regs #(.MUX_SETTLE(MS), .DIV_SETTLE(DS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    addr = a; #1; v = rd_data;
  endtask

  // Cycles during which (status & mask) != 0
  task automatic busy_len(input logic [11:0] a, input logic [31:0] mask, output int n);
    addr = a; #1; n = 0;
    while (((rd_data & mask) != 0) && n < 1000) begin
      n++; @(negedge clk); #1;
    end
  endtask

  task automatic moving_len(output int n);
    addr = 12'h400; #1; n = 0;
    while ((((rd_data / 65536) % 8) == 4) && n < 1000) begin
      n++; @(negedge clk); #1;
    end
  endtask

  function automatic logic [31:0] word_a();
    return 32'(rat[0]) + 32'(rat[1]) * 65536;
  endfunction
  function automatic logic [31:0] word_b();
    return 32'(rat[2]) + 32'(rat[3]) * 16;
  endfunction
  function automatic int lsb_of(input int f);
    return (f == 1) ? 16 : (f == 3) ? 4 : 0;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    for (int i = 0; i < 4; i++) rat[i] = '0;
    alt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    rd(12'h200, v); chk("R1 sel", v, 32'h0);
    rd(12'h400, v); chk("R1 stat", v, 32'h0001_0000);
    rd(12'h500, v); chk("R1 ratioA", v, 32'h0);
    rd(12'h504, v); chk("R1 ratioB", v, 32'h0);
    rd(12'h600, v); chk("R1 busyA", v, 32'h0);
    rd(12'h604, v); chk("R1 busyB", v, 32'h0);

    // R4 / R5 sweep of every field through every value
    for (int f = 0; f < 4; f++) begin
      for (int val = 0; val < 8; val++) begin
        logic [11:0] ra, ba;
        logic [31:0] w;
        int exp_n;
        exp_n = (rat[f] != 3'(val)) ? DS : 0;
        rat[f] = 3'(val);
        ra = (f < 2) ? 12'h500 : 12'h504;
        ba = (f < 2) ? 12'h600 : 12'h604;
        w  = (f < 2) ? word_a() : word_b();
        wr(ra, w | 32'h8000_0100);
        busy_len(ba, 32'd1 << lsb_of(f), n);
        chk("R5 busy window", 32'(n), 32'(exp_n));
        rd(ba, v); chk("R5 busy clear", v, 32'h0);
        rd(ra, v); chk("R4 ratio readback", v, w);
      end
    end

    // R6 rewrite while busy restarts (new value and same value)
    rat[0] = 3'd5;
    wr(12'h500, word_a());
    repeat (2) @(negedge clk);
    rat[0] = 3'd2;
    wr(12'h500, word_a());
    busy_len(12'h600, 32'h1, n);
    chk("R6 restart new value", 32'(n), 32'(DS));
    rat[0] = 3'd6;
    wr(12'h500, word_a());
    repeat (3) @(negedge clk);
    wr(12'h500, word_a());
    busy_len(12'h600, 32'h1, n);
    chk("R6 restart same value", 32'(n), 32'(DS));
    rd(12'h500, v); chk("R6 ratio", v, word_a());

    // R2 / R3 source mux
    wr(12'h200, 32'h0001_0000);
    moving_len(n); chk("R3 moving to alt", 32'(n), 32'(MS));
    rd(12'h400, v); chk("R2 stat alt", v, 32'h0002_0000);
    rd(12'h200, v); chk("R2 sel alt", v, 32'h0001_0000);
    wr(12'h200, 32'h0001_0000);
    moving_len(n); chk("R3 no flip no move", 32'(n), 0);
    rd(12'h400, v); chk("R3 stat alt kept", v, 32'h0002_0000);
    wr(12'h200, 32'hFFFE_FFFF);
    moving_len(n); chk("R3 moving to main", 32'(n), 32'(MS));
    rd(12'h400, v); chk("R2 stat main", v, 32'h0001_0000);
    rd(12'h200, v); chk("R2 sel other bits zero", v, 32'h0);

    // R8 flip during transition
    wr(12'h200, 32'h0001_0000);
    repeat (2) @(negedge clk);
    wr(12'h200, 32'h0);
    moving_len(n); chk("R8 restart window", 32'(n), 32'(MS));
    rd(12'h400, v); chk("R8 final main", v, 32'h0001_0000);

    // R7 unmapped and status offsets
    begin
      logic [11:0] bad [6] = '{12'h000, 12'h204, 12'h300, 12'h508, 12'h700, 12'hFFC};
      foreach (bad[k]) begin
        wr(bad[k], 32'hFFFF_FFFF);
        rd(bad[k], v); chk("R7 unmapped read", v, 32'h0);
      end
    end
    wr(12'h400, 32'hFFFF_FFFF);
    wr(12'h600, 32'hFFFF_FFFF);
    wr(12'h604, 32'hFFFF_FFFF);
    rd(12'h200, v); chk("R7 sel kept", v, 32'h0);
    rd(12'h400, v); chk("R7 stat kept", v, 32'h0001_0000);
    rd(12'h500, v); chk("R7 ratioA kept", v, word_a());
    rd(12'h504, v); chk("R7 ratioB kept", v, word_b());
    rd(12'h600, v); chk("R7 busyA idle", v, 32'h0);
    rd(12'h604, v); chk("R7 busyB idle", v, 32'h0);

    summary();
    $finish;
  end
endmodule